// File: doc/BRIEF.md
# Maskable interrupt cause register

This block collects single-cycle hardware event pulses into a cause word and raises one interrupt line while any cause bit is set and not masked. A host reaches it through a small word-addressed register port: an address, a write strobe with write data, and a read strobe whose data comes back on the following cycle.

The mask is never written as a whole word. Software sets mask bits through one address and clears them through another, so two agents can change different bits without a read-modify-write race. A mode word picks, bit by bit, how a cause bit is acknowledged: by reading it, or by writing a 1 to it. A second read view returns only the unmasked causes and acknowledges, among the clear-on-read bits, only the ones it returned.

Word offsets: 0 cause, 1 clear-mode, 2 mask-set (write-only), 3 mask-clear (write-only), 4 mask view (read-only), 5 unmasked-cause view (read-only).

Top module: `irq_cause_reg`

## Requirements
- R1: After reset the mask is all ones, every cause bit and every clear-mode bit is 0, irq_o is low and rd_data is 0.
- R2: An event pulse on bit b sets cause bit b at the next clock edge; the bit then holds until acknowledged.
- R3: A cause bit whose event pulse arrives in the same cycle as its acknowledge (by read or by write) stays set.
- R4: A write to offset 2 sets every mask bit written as 1 and leaves the other mask bits unchanged.
- R5: A write to offset 3 clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R6: A read of offset 4 returns the mask and changes no state; a read of offset 0 changes no cause bit whose clear-mode bit is 0.
- R7: A write to offset 1 stores the clear-mode word, readable at offset 1; mode bit 1 selects clear-on-read, mode bit 0 selects write-1-to-clear.
- R8: A write to offset 0 clears each cause bit written as 1 whose mode bit is 0; cause bits in clear-on-read mode ignore the write.
- R9: A read of offset 0 returns the cause word as it was before the read edge and clears the cause bits whose mode bit is 1.
- R10: A read of offset 5 returns cause AND NOT mask and clears only the clear-on-read bits among the ones it returned.
- R11: irq_o is registered: it shows, one cycle later, whether cause AND NOT mask was nonzero.
- R12: rd_data carries the read result in the cycle after rd_en; it is 0 in cycles without a read and for offsets 2, 3, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | WIDTH | Event pulses, one per cause bit |
| addr | input | AW | Word offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Read data, valid the cycle after rd_en |
| irq_o | output | 1 | Interrupt request |

## Verification
An event, write or read applied before clock edge k changes the cause, mask and mode state at edge k, and its read data shows on rd_data after that same edge, while irq_o follows one edge later at k+1, so an event reaches the interrupt line two edges after it is driven. The bench drives inputs on falling edges, advances a behavioural model on each rising edge with the same inputs, and compares rd_data and irq_o against the model on every falling edge, where both settled results are stable. Directed checks with expected values worked out from the requirements cover acknowledge races, mode-dependent clearing and the masked view.

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int WIDTH = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] event_i,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq_o
);
  localparam logic [AW-1:0] OFS_CAUSE  = AW'(0);
  localparam logic [AW-1:0] OFS_MODE   = AW'(1);
  localparam logic [AW-1:0] OFS_MSET   = AW'(2);
  localparam logic [AW-1:0] OFS_MCLR   = AW'(3);
  localparam logic [AW-1:0] OFS_MVIEW  = AW'(4);
  localparam logic [AW-1:0] OFS_UNMASK = AW'(5);
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL0 = {WIDTH{1'b0}};

  logic [WIDTH-1:0] cause_q, mask_q, mode_q, rd_q, rd_nxt;
  logic             irq_q;

  wire [WIDTH-1:0] live     = cause_q & ~mask_q;
  wire             rd_cause = rd_en && addr == OFS_CAUSE;
  wire             rd_unm   = rd_en && addr == OFS_UNMASK;
  wire [WIDTH-1:0] w1c_ack  = (wr_en && addr == OFS_CAUSE) ? (wr_data & ~mode_q) : ALL0;
  wire [WIDTH-1:0] cor_ack  = rd_cause ? mode_q : (rd_unm ? (mode_q & live) : ALL0);
  wire [WIDTH-1:0] set_w    = (wr_en && addr == OFS_MSET) ? wr_data : ALL0;
  wire [WIDTH-1:0] clr_w    = (wr_en && addr == OFS_MCLR) ? wr_data : ALL0;

  always_comb begin
    rd_nxt = ALL0;
    if (rd_en) begin
      case (addr)
        OFS_CAUSE:  rd_nxt = cause_q;
        OFS_MODE:   rd_nxt = mode_q;
        OFS_MVIEW:  rd_nxt = mask_q;
        OFS_UNMASK: rd_nxt = live;
        default:    rd_nxt = ALL0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= ALL0;
      mask_q  <= ALL1;
      mode_q  <= ALL0;
      rd_q    <= ALL0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~(w1c_ack | cor_ack)) | event_i;
      mask_q  <= (mask_q | set_w) & ~clr_w;
      if (wr_en && addr == OFS_MODE) mode_q <= wr_data;
      rd_q    <= rd_nxt;
      irq_q   <= |live;
    end
  end

  assign rd_data = rd_q;
  assign irq_o   = irq_q;

  assert_event_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(event_i)) == $past(event_i)));

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MSET) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  assert_mask_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MCLR) |=> ((mask_q & $past(wr_data)) == ALL0));

  assert_view_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_MVIEW && !wr_en && event_i == ALL0) |=> ($stable(cause_q) && $stable(mask_q)));

  assert_cor_ignores_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CAUSE && !rd_en) |=> ((cause_q & $past(cause_q & mode_q)) == $past(cause_q & mode_q)));

  assert_quiet_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(live) == ALL0) |-> !irq_o);
endmodule

// File: tb/tb_irq_cause_reg.sv
`timescale 1ns/1ps
module tb_irq_cause_reg;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] event_i = '0, wr_data = '0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] rd_data;
  logic irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_cause_reg #(.WIDTH(W), .AW(3)) dut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o));

  bit [W-1:0] m_cause, m_mask, m_mode, m_rd;
  bit m_irq;

  always @(posedge clk) begin
    bit [W-1:0] c, k, md, r, ack, vis;
    bit q;
    c = m_cause; k = m_mask; md = m_mode; r = 0; ack = 0;
    vis = m_cause & ~m_mask;
    q = (vis != 0);
    if (!rst_n) begin
      m_cause = 0; m_mask = '1; m_mode = 0; m_rd = 0; m_irq = 0;
    end else begin
      if (rd_en) begin
        if (addr == 0) begin r = m_cause; ack = m_mode; end
        else if (addr == 1) r = m_mode;
        else if (addr == 4) r = m_mask;
        else if (addr == 5) begin r = vis; ack = vis & m_mode; end
      end
      if (wr_en) begin
        if (addr == 0) ack = ack | (wr_data & ~m_mode);
        if (addr == 1) md = wr_data;
        if (addr == 2) k = k | wr_data;
        if (addr == 3) k = k & ~wr_data;
      end
      c = (c & ~ack) | event_i;
      m_cause = c; m_mask = k; m_mode = md; m_rd = r; m_irq = q;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R12 per-cycle rd_data", rd_data, m_rd);
    chk("R11 per-cycle irq_o", {31'b0, irq_o}, {31'b0, m_irq});
  end

  task automatic cyc(input logic [W-1:0] ev, input logic we, input logic re,
                     input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    event_i = ev; wr_en = we; rd_en = re; addr = a; wr_data = d;
    @(negedge clk);
    event_i = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string req);
    cyc('0, 1'b0, 1'b1, a, '0);
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cyc('0, 1'b1, 1'b0, a, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 rd_data after reset", rd_data, 32'h0);
    rd(3'd4, 32'hFFFF_FFFF, "R1 mask all ones");
    rd(3'd0, 32'h0, "R1 cause zero");
    rd(3'd1, 32'h0, "R1 mode zero");
    cyc(32'h5, 1'b0, 1'b0, 3'd0, '0);
    rd(3'd0, 32'h5, "R2 event latched");
    rd(3'd0, 32'h5, "R6 W1C read keeps cause");
    chk("R11 masked cause no irq", {31'b0, irq_o}, 32'h0);
    wr(3'd3, 32'h1);
    @(negedge clk);
    chk("R11 irq after unmask", {31'b0, irq_o}, 32'h1);
    rd(3'd4, 32'hFFFF_FFFE, "R5 mask clear");
    wr(3'd2, 32'h1);
    rd(3'd4, 32'hFFFF_FFFF, "R4 mask set");
    chk("R11 irq drops after mask", {31'b0, irq_o}, 32'h0);
    wr(3'd0, 32'h4);
    rd(3'd0, 32'h1, "R8 W1C clears written bit");
    wr(3'd1, 32'hF0);
    rd(3'd1, 32'hF0, "R7 mode readback");
    cyc(32'h30, 1'b0, 1'b0, 3'd0, '0);
    rd(3'd0, 32'h31, "R9 read returns before clear");
    rd(3'd0, 32'h01, "R9 COR bits cleared");
    cyc(32'h10, 1'b0, 1'b0, 3'd0, '0);
    wr(3'd0, 32'h10);
    rd(3'd0, 32'h11, "R8 COR bit ignores write");
    rd(3'd0, 32'h01, "R9 cleared by read");
    cyc(32'h2, 1'b1, 1'b0, 3'd0, 32'h2);
    rd(3'd0, 32'h03, "R3 event beats W1C");
    cyc(32'h20, 1'b0, 1'b1, 3'd0, '0);
    chk("R3 read before event", rd_data, 32'h03);
    rd(3'd0, 32'h23, "R3 event beats COR");
    rd(3'd0, 32'h03, "R3 then cleared");
    wr(3'd3, 32'h11);
    cyc(32'h10, 1'b0, 1'b0, 3'd0, '0);
    rd(3'd5, 32'h11, "R10 unmasked view");
    rd(3'd0, 32'h03, "R10 only returned COR bits cleared");
    chk("R11 irq with unmasked cause", {31'b0, irq_o}, 32'h1);
    rd(3'd2, 32'h0, "R12 mask-set offset reads zero");
    rd(3'd7, 32'h0, "R12 unused offset reads zero");
    wr(3'd0, 32'h3);
    @(negedge clk);
    chk("R11 irq low after acknowledge", {31'b0, irq_o}, 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule